// File: doc/BRIEF.md
# Multi-Source 8-Bit PWM Bank

A bank of independent 8-bit pulse-width modulators that share one system clock. Each channel advances its counter on a tick strobe taken from one of six timebases: every system cycle, three fixed prescaled rates, a shared programmable divider, or the period wrap of the neighbouring channel. Every timebase is a one-cycle enable strobe in the system clock domain, so the whole bank runs on one clock.

Each channel has a period, a pulse width and a source code. A new period or width takes effect only at the channel's next period boundary, so an update never cuts a pulse short. A per-pin select mask places a channel's output on a port pin in place of the pin's ordinary output data. A one-cycle event pulse flags every change of a channel's output level for the interrupt logic.

Top module: `pwm_bank`

## Requirements
- R1: With period P (P of 0 or 1 acts as 1) and width W, a channel repeats every P ticks. Its output is high for the first min(W,P) ticks of each cycle and low for the rest.
- R2: Source codes select the tick: 0 every system cycle, 1 every DIV_FAST cycles, 2 every DIV_MID cycles, 3 every DIV_SLOW cycles, 4 the programmable divider, 5 the chained source of R10.
- R3: The programmable divider strobes once every ratio_i strobes of the DIV_FAST rate (ratio 1 to 255). A ratio of 0 acts as 1.
- R4: A width of 0 keeps the output low. A width at or above the period keeps it high, with no edges.
- R5: Period and width values on the inputs are taken up only when the channel's counter wraps. A pulse already in progress keeps its old width.
- R6: Source codes 6 and 7 give no ticks, so the channel output stays frozen and produces no events.
- R7: Pin p is driven by channel p mod N_CH when pin_sel_i[p] is 1, and by pin_data_i[p] when it is 0.
- R8: evt_o[c] is high for exactly one cycle in the same cycle that pwm_o[c] differs from its value in the previous cycle, and low otherwise.
- R9: While rst_ni is low, all channel outputs and all event outputs are 0.
- R10: Under source code 5, channel c ticks once for each period wrap of channel (c-1) mod N_CH. The tick comes one cycle after that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_ratio_i | input | 8 | Programmable divider ratio |
| src_sel_i | input | 3*N_CH | Per-channel source code, 3 bits per channel |
| period_i | input | 8*N_CH | Per-channel period in ticks |
| width_i | input | 8*N_CH | Per-channel pulse width in ticks |
| pin_sel_i | input | N_PIN | 1 routes the mapped channel to the pin |
| pin_data_i | input | N_PIN | Ordinary pin output data |
| pin_o | output | N_PIN | Pin output values |
| pwm_o | output | N_CH | Channel output levels |
| evt_o | output | N_CH | Output-change event pulses |

## Verification
The pin mux is combinational, so pin results are checked one time step after the inputs change. Channel waveforms depend on prescaler phase, so they are measured over windows that span a whole number of periods after a settling wait longer than the old and new periods combined. The count of high samples and edges in such a window does not depend on phase. The boundary rule is checked directly: width is changed on the cycle a pulse rises, and the bench expects the old width on that pulse and the new width on the next one. Event pulses are compared, on every sampled cycle, with the level change seen on pwm_o during that same cycle.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned SRC_W = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_SYS   = 3'd0,
    SRC_FAST  = 3'd1,
    SRC_MID   = 3'd2,
    SRC_SLOW  = 3'd3,
    SRC_PROG  = 3'd4,
    SRC_CHAIN = 3'd5
  } src_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned DIV_FAST = 16,
  parameter int unsigned DIV_MID  = 256,
  parameter int unsigned DIV_SLOW = 750
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] ratio_i,
  output logic       fast_o,
  output logic       mid_o,
  output logic       slow_o,
  output logic       prog_o
);
  logic [2:0] stb;

  for (genvar g = 0; g < 3; g++) begin : g_div
    localparam int unsigned D = (g == 0) ? DIV_FAST : (g == 1) ? DIV_MID : DIV_SLOW;
    if (D <= 1) begin : g_pass
      assign stb[g] = 1'b1;
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(D);
      logic [CW-1:0] cnt_q;
      assign stb[g] = (cnt_q == CW'(D - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (stb[g]) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
      // R2: a divided rate strobes for one cycle only
      a_r2_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb[g] |=> !stb[g]);
    end
  end

  assign fast_o = stb[0];
  assign mid_o  = stb[1];
  assign slow_o = stb[2];

  // shared programmable divider, counts fast strobes
  logic [7:0] pcnt_q;
  logic [7:0] eff_ratio;
  logic       hit;
  assign eff_ratio = (ratio_i == 8'd0) ? 8'd1 : ratio_i;
  assign hit       = ({1'b0, pcnt_q} + 9'd1) >= {1'b0, eff_ratio};
  assign prog_o    = fast_o & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (fast_o) pcnt_q <= hit ? 8'd0 : pcnt_q + 8'd1;
  end

  // R3: with a ratio above one the divider never strobes on back-to-back cycles
  a_r3_prog_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_o && ratio_i > 8'd1) |=> (!prog_o || ratio_i < 8'd2));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             out_o,
  output logic             wrap_o,
  output logic             evt_o
);
  logic [CNT_W-1:0] cnt_q, per_q, wid_q;
  logic             prev_q;
  logic             at_end;

  assign at_end = ({1'b0, cnt_q} + 1'b1) >= {1'b0, per_q};
  assign wrap_o = tick_i & at_end;
  assign out_o  = cnt_q < wid_q;
  assign evt_o  = out_o ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      wid_q <= '0;
    end else if (tick_i) begin
      if (at_end) begin
        cnt_q <= '0;
        per_q <= period_i;   // shadow load at boundary only
        wid_q <= width_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= out_o;
  end

  // R6: counter moves only on a tick
  a_r6_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  // R1: counter stays inside the active period
  a_r1_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) || (cnt_q < per_q));
  // R5: active width and period change only at a period start
  a_r5_width_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wid_q) |-> (cnt_q == '0));
  a_r5_period_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(per_q) |-> (cnt_q == '0));
endmodule

// File: rtl/pwm_pin_mux.sv
module pwm_pin_mux #(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned N_PIN = 60
) (
  input  logic [N_CH-1:0]  pwm_i,
  input  logic [N_PIN-1:0] sel_i,
  input  logic [N_PIN-1:0] data_i,
  output logic [N_PIN-1:0] pin_o
);
  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    localparam int unsigned CH = p % N_CH;
    assign pin_o[p] = sel_i[p] ? pwm_i[CH] : data_i[p];
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned N_CH     = 16,
  parameter int unsigned N_PIN    = 60,
  parameter int unsigned DIV_FAST = 16,
  parameter int unsigned DIV_MID  = 256,
  parameter int unsigned DIV_SLOW = 750
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [7:0]             div_ratio_i,
  input  logic [SRC_W*N_CH-1:0]  src_sel_i,
  input  logic [CNT_W*N_CH-1:0]  period_i,
  input  logic [CNT_W*N_CH-1:0]  width_i,
  input  logic [N_PIN-1:0]       pin_sel_i,
  input  logic [N_PIN-1:0]       pin_data_i,
  output logic [N_PIN-1:0]       pin_o,
  output logic [N_CH-1:0]        pwm_o,
  output logic [N_CH-1:0]        evt_o
);
  logic fast_stb, mid_stb, slow_stb, prog_stb;
  logic [N_CH-1:0] tick, wrap, wrap_q;

  pwm_timebase #(
    .DIV_FAST(DIV_FAST),
    .DIV_MID (DIV_MID),
    .DIV_SLOW(DIV_SLOW)
  ) u_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ratio_i(div_ratio_i),
    .fast_o (fast_stb),
    .mid_o  (mid_stb),
    .slow_o (slow_stb),
    .prog_o (prog_stb)
  );

  // registered wraps break the ring of chained channels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wrap_q <= '0;
    else         wrap_q <= wrap;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam int unsigned PREV = (i + N_CH - 1) % N_CH;
    src_e src;
    assign src = src_e'(src_sel_i[i*SRC_W +: SRC_W]);

    always_comb begin
      unique case (src)
        SRC_SYS:   tick[i] = 1'b1;
        SRC_FAST:  tick[i] = fast_stb;
        SRC_MID:   tick[i] = mid_stb;
        SRC_SLOW:  tick[i] = slow_stb;
        SRC_PROG:  tick[i] = prog_stb;
        SRC_CHAIN: tick[i] = wrap_q[PREV];
        default:   tick[i] = 1'b0;
      endcase
    end

    pwm_channel u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick[i]),
      .period_i(period_i[i*CNT_W +: CNT_W]),
      .width_i (width_i[i*CNT_W +: CNT_W]),
      .out_o   (pwm_o[i]),
      .wrap_o  (wrap[i]),
      .evt_o   (evt_o[i])
    );

    // R10: a chained channel ticks only right after its neighbour wraps
    a_r10_chain_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src == SRC_CHAIN && tick[i]) |-> $past(wrap[PREV]));
  end

  pwm_pin_mux #(
    .N_CH (N_CH),
    .N_PIN(N_PIN)
  ) u_mux (
    .pwm_i (pwm_o),
    .sel_i (pin_sel_i),
    .data_i(pin_data_i),
    .pin_o (pin_o)
  );
endmodule

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
  localparam int CLK_NS = 10;
  localparam int NCH = 4;
  localparam int NPIN = 8;
  localparam int DF = 2, DM = 3, DS = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ratio = 8'd1;
  logic [3*NCH-1:0] src = '0;
  logic [8*NCH-1:0] per = '0, wid = '0;
  logic [NPIN-1:0] psel = '0, pdat = '0;
  logic [NPIN-1:0] pin;
  logic [NCH-1:0] pwm, evt;
  int checks = 0, errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  pwm_bank #(.N_CH(NCH), .N_PIN(NPIN), .DIV_FAST(DF), .DIV_MID(DM), .DIV_SLOW(DS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .div_ratio_i(ratio), .src_sel_i(src),
    .period_i(per), .width_i(wid), .pin_sel_i(psel), .pin_data_i(pdat),
    .pin_o(pin), .pwm_o(pwm), .evt_o(evt));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ch(input int c, input int s, input int p, input int w);
    src[c*3 +: 3] = 3'(s);
    per[c*8 +: 8] = 8'(p);
    wid[c*8 +: 8] = 8'(w);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts high samples, level changes and event mismatches over n cycles
  task automatic measure(input int c, input int n, output int hi, output int edges, output int bad);
    logic last;
    hi = 0; edges = 0; bad = 0;
    @(negedge clk);
    last = pwm[c];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm[c]) hi++;
      if (pwm[c] != last) edges++;
      if (evt[c] != (pwm[c] != last)) bad++;
      last = pwm[c];
    end
  endtask

  function automatic int exp_hi(input int p, input int w, input int d, input int n);
    int pe = (p < 1) ? 1 : p;
    int we = (w < pe) ? w : pe;
    return (n / (pe * d)) * we * d;
  endfunction

  function automatic int exp_edges(input int p, input int w, input int d, input int n);
    int pe = (p < 1) ? 1 : p;
    return (w > 0 && w < pe) ? 2 * (n / (pe * d)) : 0;
  endfunction

  task automatic run_case(input string req, input int c, input int s, input int p,
                          input int w, input int d, input int settle, input int n);
    int hi, ed, bad;
    set_ch(c, s, p, w);
    wait_cyc(settle);
    measure(c, n, hi, ed, bad);
    check(hi == exp_hi(p, w, d, n), {req, " high time"}, hi, exp_hi(p, w, d, n));
    check(ed == exp_edges(p, w, d, n), {req, " edges"}, ed, exp_edges(p, w, d, n));
    check(bad == 0, "R8 event matches level change", bad, 0);
  endtask

  initial begin : watchdog
    #(CLK_NS * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int hi, ed, bad, n;
    int seed;
    seed = 7;
    void'($urandom(seed));
    for (int c = 0; c < NCH; c++) set_ch(c, 0, 10, 5);
    psel = '1;
    wait_cyc(3);
    // R9 reset state, pins selected to channels read 0
    check(pwm == '0, "R9 pwm in reset", int'(pwm), 0);
    check(evt == '0, "R9 evt in reset", int'(evt), 0);
    check(pin == '0, "R9 pins in reset", int'(pin), 0);
    psel = '0; pdat = 8'hA5; #1;
    check(pin == 8'hA5, "R7 data path in reset", int'(pin), 8'hA5);
    @(negedge clk); rst_n = 1'b1;

    // R1 basic waveform, source 0
    run_case("R1 P10 W3", 0, 0, 10, 3, 1, 40, 50);
    run_case("R1 P0 acts as 1", 0, 0, 0, 1, 1, 30, 20);
    run_case("R1 P1 W0", 0, 0, 1, 0, 1, 30, 20);
    // R4 constant levels
    run_case("R4 W0 low", 0, 0, 8, 0, 1, 30, 40);
    run_case("R4 W=P high", 0, 0, 8, 8, 1, 30, 40);
    run_case("R4 W200 high", 0, 0, 8, 200, 1, 30, 40);
    // R2 fixed sources
    run_case("R2 fast", 1, 1, 6, 2, DF, 60, 6*DF*4);
    run_case("R2 mid", 2, 2, 6, 4, DM, 60, 6*DM*4);
    run_case("R2 slow", 3, 3, 4, 1, DS, 60, 4*DS*4);
    // R3 programmable divider, ratio 0 behaves as 1
    ratio = 8'd0;
    run_case("R3 ratio0", 2, 4, 5, 2, DF, 80, 100);
    ratio = 8'd3;
    run_case("R3 ratio3", 2, 4, 5, 2, DF*3, 120, 120);

    // R5 width change mid-pulse applies at the next boundary
    set_ch(0, 0, 10, 3);
    wait_cyc(30);
    begin
      logic last;
      last = pwm[0];
      forever begin @(negedge clk); if (pwm[0] && !last) break; last = pwm[0]; end
      wid[0 +: 8] = 8'd7;
      n = 1;
      forever begin @(negedge clk); if (!pwm[0]) break; n++; end
      check(n == 3, "R5 old width kept", n, 3);
      forever begin @(negedge clk); if (pwm[0]) break; end
      n = 1;
      forever begin @(negedge clk); if (!pwm[0]) break; n++; end
      check(n == 7, "R5 new width used", n, 7);
    end

    // R6 codes 6 and 7 freeze the channel
    for (int code = 6; code <= 7; code++) begin
      set_ch(0, 0, 10, 5);
      wait_cyc(23);
      src[0 +: 3] = 3'(code);
      wait_cyc(2);
      measure(0, 60, hi, ed, bad);
      check(ed == 0 && (hi == 0 || hi == 60), "R6 frozen output", ed, 0);
      check(bad == 0 && evt[0] == 1'b0, "R6 no events", bad, 0);
    end

    // R10 chained source: ch1 ticks on each wrap of ch0
    set_ch(0, 0, 4, 2);
    set_ch(1, 5, 3, 1);
    wait_cyc(100);
    measure(1, 120, hi, ed, bad);
    check(hi == 40, "R10 chained high time", hi, 40);
    check(ed == 20, "R10 chained edges", ed, 20);
    check(bad == 0, "R8 chained events", bad, 0);

    // randomized waveform trials over sources 0..4
    for (int t = 0; t < 25; t++) begin
      int c, s, p, w, r, d;
      c = $urandom_range(0, NCH-1);
      s = $urandom_range(0, 4);
      p = $urandom_range(2, 16);
      w = $urandom_range(0, p + 2);
      r = $urandom_range(1, 4);
      ratio = 8'(r);
      d = (s == 0) ? 1 : (s == 1) ? DF : (s == 2) ? DM : (s == 3) ? DS : DF * r;
      for (int k = 0; k < NCH; k++) if (k != c) set_ch(k, 0, 4, 2);
      run_case("R2 R1 random", c, s, p, w, d, 300, 2 * p * d);
    end

    // R7 pin routing: odd channels held high, even channels held low
    for (int c = 0; c < NCH; c++) set_ch(c, 0, 4, (c % 2) ? 255 : 0);
    wait_cyc(20);
    for (int t = 0; t < 10; t++) begin
      logic [NPIN-1:0] e;
      @(negedge clk);
      psel = 8'($urandom); pdat = 8'($urandom);
      #1;
      for (int p = 0; p < NPIN; p++) e[p] = psel[p] ? ((p % NCH) % 2 == 1) : pdat[p];
      check(pin == e, "R7 pin mux", int'(pin), int'(e));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule